// File: doc/BRIEF.md
# Private interrupt register bank

A per-core register file for 32 private interrupts. Numbers 0 to 15 are software-generated (SGI) and 16 to 31 are peripheral (PPI). It holds each interrupt's group, group modifier, enable, pending, active, priority, trigger mode and non-secure SGI permission. It presents enable, pending, active, group and priority state to a separate priority arbiter. Software reaches the bank through a single-cycle register port. Each access carries a secure attribute, and a global input turns security off.

When security is on, a non-secure access sees a filtered view. Bits of group-0 interrupts read as zero and ignore writes. Priorities are shown shifted into the non-secure range. Sixteen level inputs feed the PPIs. A request port raises SGIs after checking the requested group and the non-secure permission field.

Top module: `prv_irq_bank`

## Requirements
- R1: After reset, enable, pending, active, group, group-modifier, permission and sleep state are zero, every priority is zero, SGIs are edge-triggered and PPIs are level-triggered.
- R2: A word write of ones sets bits: at 0x100 for enable, 0x200 for pending, 0x300 for active. A word write of ones clears bits at 0x180, 0x280 and 0x380. A read at either offset of a pair returns the state. Read data appears on `rdata_o` one clock after the request.
- R3: With security on (`sec_disable_i`=0) and `secure_i`=0, R2 accesses act only on bits whose group bit is 1. Other bits read 0.
- R4: Priorities are 8 bits per interrupt at bytes 0x400+n. A word access at 0x400+4k covers interrupts 4k..4k+3, with the lowest interrupt in bits 7:0. Byte accesses are allowed only in this range.
- R5: A non-secure access with security on reads a group-1 priority p as (p<<1)&0xFF. A write of v stores 0x80|(v>>1). Group-0 priorities read 0 and ignore writes.
- R6: A pending read, and `pending_o`, is the pending latch ORed with the live level of each level-triggered PPI.
- R7: Trigger registers hold 2 bits per interrupt, with bit 2i+1 = 1 meaning edge: 0xC00 for 0..15, 0xC04 for 16..31. 0xC00 ignores writes. 0xC04 is writable, subject to the R3 group mask, which also applies to reads.
- R8: A rising PPI input sets its pending latch only if that PPI is edge-triggered.
- R9: The group modifier (0xD00) and the permission fields (0xE00, 2 bits per SGI, SGI n at bits 2n+1:2n) read 0 and ignore writes when security is off or the access is non-secure.
- R10: The group register (0x080) reads 0 and ignores writes for non-secure accesses while security is on.
- R11: SGI groups are coded 0 = group 0, 1 = secure group 1, 2 = non-secure group 1. The configured group is non-secure group 1 when the group bit is 1. It is secure group 1 when the group bit is 0, the modifier bit is 1 and security is on. Otherwise it is group 0. A request is accepted when the requested and configured groups match, or when it asks for secure group 1 on a group-0 interrupt. Any other request is dropped.
- R12: A non-secure SGI request with security on, aimed at an interrupt whose configured group is secure, also needs its permission field to be at least 1 (group 0) or at least 2 (secure group 1). Otherwise it is dropped.
- R13: At 0x000 only bit 0 (sleep request) is writable. Bit 1 (asleep) always reads equal to bit 0.
- R14: Unmapped offsets, misaligned word accesses and byte accesses outside the priority range read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_disable_i | input | 1 | Security off when 1 |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| secure_i | input | 1 | Secure access attribute |
| word_i | input | 1 | 1 = 32-bit access, 0 = byte access |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data (byte data in bits 7:0) |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| ppi_level_i | input | 16 | Peripheral lines for interrupts 16..31 |
| sgi_req_i | input | 1 | SGI request strobe |
| sgi_id_i | input | 4 | SGI number |
| sgi_grp_i | input | 2 | Requested group |
| sgi_secure_i | input | 1 | Request comes from the secure side |
| group_o | output | 32 | Group bits |
| grpmod_o | output | 32 | Group-modifier bits |
| enable_o | output | 32 | Enable bits |
| pending_o | output | 32 | Effective pending (latch OR level) |
| active_o | output | 32 | Active bits |
| prio_o | output | 256 | Priorities, interrupt n at bits 8n+7:8n |

## Verification
Every stored-state change is due on the first rising edge after the strobe or input change. This holds for register writes, SGI requests and PPI edges. The bench therefore samples the state outputs at the falling edge after that rising edge. Read data is registered, so the expected word is queued when the read is driven. The monitor compares it one falling edge later, at the edge where it sees that the previous rising edge captured a read. Level-triggered pending is combinational from the input, so it is checked at the falling edge after the line changes.

// File: rtl/prv_irq_pkg.sv
package prv_irq_pkg;
  localparam int N_SGI  = 16;
  localparam int N_PPI  = 16;
  localparam int N_IRQ  = N_SGI + N_PPI;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = $clog2(N_IRQ);

  localparam logic [ADDR_W-1:0] OFF_SLEEP = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_GROUP = 12'h080;
  localparam logic [ADDR_W-1:0] OFF_SEN   = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_CEN   = 12'h180;
  localparam logic [ADDR_W-1:0] OFF_SPEND = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_CPEND = 12'h280;
  localparam logic [ADDR_W-1:0] OFF_SACT  = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_CACT  = 12'h380;
  localparam logic [ADDR_W-1:0] OFF_PRIO  = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_CFG0  = 12'hC00;
  localparam logic [ADDR_W-1:0] OFF_CFG1  = 12'hC04;
  localparam logic [ADDR_W-1:0] OFF_GMOD  = 12'hD00;
  localparam logic [ADDR_W-1:0] OFF_NSAC  = 12'hE00;

  localparam logic [1:0] GRP_0   = 2'd0;
  localparam logic [1:0] GRP_1S  = 2'd1;
  localparam logic [1:0] GRP_1NS = 2'd2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SLEEP, SEL_GROUP, SEL_SEN, SEL_CEN, SEL_SPEND, SEL_CPEND,
    SEL_SACT, SEL_CACT, SEL_PRIO, SEL_CFG0, SEL_CFG1, SEL_GMOD, SEL_NSAC
  } reg_sel_e;

  function automatic logic [N_IRQ-1:0] spread_odd(input logic [N_IRQ/2-1:0] h);
    logic [N_IRQ-1:0] r;
    r = '0;
    for (int k = 0; k < N_IRQ/2; k++) r[2*k+1] = h[k];
    return r;
  endfunction

  function automatic logic [N_IRQ/2-1:0] gather_odd(input logic [N_IRQ-1:0] w);
    logic [N_IRQ/2-1:0] r;
    for (int k = 0; k < N_IRQ/2; k++) r[k] = w[2*k+1];
    return r;
  endfunction
endpackage

// File: rtl/prv_addr_dec.sv
module prv_addr_dec
  import prv_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int PRIO_LSB = $clog2(N_IRQ);

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = addr_i[IDX_W-1:0];
    if (addr_i[ADDR_W-1:PRIO_LSB] == OFF_PRIO[ADDR_W-1:PRIO_LSB]) begin
      if (!word_i || addr_i[1:0] == 2'b00) sel_o = SEL_PRIO;
    end else if (word_i && addr_i[1:0] == 2'b00) begin
      unique case (addr_i)
        OFF_SLEEP: sel_o = SEL_SLEEP;
        OFF_GROUP: sel_o = SEL_GROUP;
        OFF_SEN:   sel_o = SEL_SEN;
        OFF_CEN:   sel_o = SEL_CEN;
        OFF_SPEND: sel_o = SEL_SPEND;
        OFF_CPEND: sel_o = SEL_CPEND;
        OFF_SACT:  sel_o = SEL_SACT;
        OFF_CACT:  sel_o = SEL_CACT;
        OFF_CFG0:  sel_o = SEL_CFG0;
        OFF_CFG1:  sel_o = SEL_CFG1;
        OFF_GMOD:  sel_o = SEL_GMOD;
        OFF_NSAC:  sel_o = SEL_NSAC;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/prv_prio_file.sv
module prv_prio_file
  import prv_irq_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    word_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [31:0]             wdata_i,
  input  logic                    ns_view_i,
  input  logic [N_IRQ-1:0]        group_i,
  output logic [31:0]             rdata_o,
  output logic [N_IRQ*PRIO_W-1:0] prio_o
);
  logic [PRIO_W-1:0] prio_q [N_IRQ];
  logic [PRIO_W-1:0] rv     [N_IRQ];

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    logic              hit;
    logic [PRIO_W-1:0] wb;

    assign hit = we_i && (word_i ? (IDX[IDX_W-1:2] == idx_i[IDX_W-1:2]) : (IDX == idx_i));
    assign wb  = word_i ? wdata_i[PRIO_W*(i%4) +: PRIO_W] : wdata_i[PRIO_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[i] <= '0;
      else if (hit && (!ns_view_i || group_i[i]))
        prio_q[i] <= ns_view_i ? {1'b1, wb[PRIO_W-1:1]} : wb;
    end

    // non-secure view: halve-range remap, group-0 hidden
    assign rv[i] = !ns_view_i ? prio_q[i] :
                   group_i[i] ? {prio_q[i][PRIO_W-2:0], 1'b0} : '0;
    assign prio_o[PRIO_W*i +: PRIO_W] = prio_q[i];

    assert_ns_prio_wi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && ns_view_i && !group_i[i]) |=> $stable(prio_q[i]));
  end

  always_comb begin
    if (word_i)
      rdata_o = {rv[{idx_i[IDX_W-1:2], 2'd3}], rv[{idx_i[IDX_W-1:2], 2'd2}],
                 rv[{idx_i[IDX_W-1:2], 2'd1}], rv[{idx_i[IDX_W-1:2], 2'd0}]};
    else
      rdata_o = {24'b0, rv[idx_i]};
  end
endmodule

// File: rtl/prv_sgi_gate.sv
module prv_sgi_gate
  import prv_irq_pkg::*;
(
  input  logic             req_i,
  input  logic [3:0]       id_i,
  input  logic [1:0]       grp_i,
  input  logic             secure_i,
  input  logic             sec_disable_i,
  input  logic [N_IRQ-1:0] group_i,
  input  logic [N_IRQ-1:0] grpmod_i,
  input  logic [N_IRQ-1:0] nsacr_i,
  output logic [N_IRQ-1:0] set_o
);
  logic [1:0] cfg, ns_f;
  logic       match, ok;

  always_comb begin
    if (group_i[id_i])                         cfg = GRP_1NS;
    else if (!sec_disable_i && grpmod_i[id_i]) cfg = GRP_1S;
    else                                       cfg = GRP_0;
    ns_f  = {nsacr_i[{id_i, 1'b1}], nsacr_i[{id_i, 1'b0}]};
    match = (grp_i == cfg) || (grp_i == GRP_1S && cfg == GRP_0);
    ok    = secure_i || sec_disable_i || cfg == GRP_1NS ||
            ((cfg == GRP_0) ? (ns_f != 2'd0) : ns_f[1]);
    set_o = (req_i && match && ok) ? (N_IRQ'(1) << id_i) : '0;
  end
endmodule

// File: rtl/prv_ctl_regs.sv
module prv_ctl_regs
  import prv_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [31:0]      wdata_i,
  input  logic             ns_view_i,
  input  logic             sec_bank_i,
  input  logic [N_PPI-1:0] ppi_level_i,
  input  logic [N_IRQ-1:0] sgi_set_i,
  output logic [N_IRQ-1:0] group_o,
  output logic [N_IRQ-1:0] grpmod_o,
  output logic [N_IRQ-1:0] nsacr_o,
  output logic [N_IRQ-1:0] en_o,
  output logic [N_IRQ-1:0] pend_o,
  output logic [N_IRQ-1:0] act_o,
  output logic [N_IRQ-1:0] edge_o,
  output logic             sleep_o
);
  localparam logic [N_IRQ-1:0] EDGE_RST = {{N_PPI{1'b0}}, {N_SGI{1'b1}}};

  logic [N_IRQ-1:0] mask, wm, pend_n, en_n, act_n, rise;
  logic [N_PPI-1:0] lvl_q, cfg_w, cfg_m;

  assign mask  = ns_view_i ? group_o : '1;
  assign wm    = wdata_i & mask;
  assign rise  = {ppi_level_i & ~lvl_q & edge_o[N_IRQ-1:N_SGI], {N_SGI{1'b0}}};
  assign cfg_w = gather_odd(wdata_i);
  assign cfg_m = mask[N_IRQ-1:N_SGI];

  always_comb begin
    en_n   = en_o;
    pend_n = pend_o;
    act_n  = act_o;
    if (we_i) begin
      unique case (sel_i)
        SEL_SEN:   en_n   = en_o | wm;
        SEL_CEN:   en_n   = en_o & ~wm;
        SEL_SPEND: pend_n = pend_o | wm;
        SEL_CPEND: pend_n = pend_o & ~wm;
        SEL_SACT:  act_n  = act_o | wm;
        SEL_CACT:  act_n  = act_o & ~wm;
        default: ;
      endcase
    end
    pend_n = pend_n | sgi_set_i | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_o  <= '0;
      grpmod_o <= '0;
      nsacr_o  <= '0;
      en_o     <= '0;
      pend_o   <= '0;
      act_o    <= '0;
      edge_o   <= EDGE_RST;
      sleep_o  <= 1'b0;
      lvl_q    <= '0;
    end else begin
      en_o   <= en_n;
      pend_o <= pend_n;
      act_o  <= act_n;
      lvl_q  <= ppi_level_i;
      if (we_i) begin
        if (sel_i == SEL_GROUP && !ns_view_i) group_o  <= wdata_i;
        if (sel_i == SEL_GMOD && sec_bank_i)  grpmod_o <= wdata_i;
        if (sel_i == SEL_NSAC && sec_bank_i)  nsacr_o  <= wdata_i;
        if (sel_i == SEL_SLEEP)               sleep_o  <= wdata_i[0];
        if (sel_i == SEL_CFG1)
          edge_o[N_IRQ-1:N_SGI] <= (edge_o[N_IRQ-1:N_SGI] & ~cfg_m) | (cfg_w & cfg_m);
      end
    end
  end

  assert_grp_ns_wi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_GROUP && ns_view_i) |=> $stable(group_o));

  assert_ppi_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

  assert_sgi_cfg_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o[N_SGI-1:0] == {N_SGI{1'b1}});
endmodule

// File: rtl/prv_irq_bank.sv
module prv_irq_bank
  import prv_irq_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sec_disable_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic                    secure_i,
  input  logic                    word_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [N_PPI-1:0]        ppi_level_i,
  input  logic                    sgi_req_i,
  input  logic [3:0]              sgi_id_i,
  input  logic [1:0]              sgi_grp_i,
  input  logic                    sgi_secure_i,
  output logic [N_IRQ-1:0]        group_o,
  output logic [N_IRQ-1:0]        grpmod_o,
  output logic [N_IRQ-1:0]        enable_o,
  output logic [N_IRQ-1:0]        pending_o,
  output logic [N_IRQ-1:0]        active_o,
  output logic [N_IRQ*PRIO_W-1:0] prio_o
);
  reg_sel_e         sel;
  logic [IDX_W-1:0] idx;
  logic             ns_view, sec_bank, wr, sleep;
  logic [N_IRQ-1:0] nsacr, pend_l, edge_m, sgi_set, mask;
  logic [31:0]      prio_rd, rd_mux, rdata_q;

  assign ns_view  = !secure_i && !sec_disable_i;
  assign sec_bank = secure_i && !sec_disable_i;
  assign wr       = req_i && we_i;

  prv_addr_dec u_dec (.addr_i(addr_i), .word_i(word_i), .sel_o(sel), .idx_o(idx));

  prv_sgi_gate u_sgi (
    .req_i(sgi_req_i), .id_i(sgi_id_i), .grp_i(sgi_grp_i), .secure_i(sgi_secure_i),
    .sec_disable_i(sec_disable_i), .group_i(group_o), .grpmod_i(grpmod_o),
    .nsacr_i(nsacr), .set_o(sgi_set)
  );

  prv_ctl_regs u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr), .sel_i(sel), .wdata_i(wdata_i),
    .ns_view_i(ns_view), .sec_bank_i(sec_bank), .ppi_level_i(ppi_level_i),
    .sgi_set_i(sgi_set), .group_o(group_o), .grpmod_o(grpmod_o), .nsacr_o(nsacr),
    .en_o(enable_o), .pend_o(pend_l), .act_o(active_o), .edge_o(edge_m), .sleep_o(sleep)
  );

  prv_prio_file u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr && sel == SEL_PRIO), .word_i(word_i),
    .idx_i(idx), .wdata_i(wdata_i), .ns_view_i(ns_view), .group_i(group_o),
    .rdata_o(prio_rd), .prio_o(prio_o)
  );

  assign pending_o = pend_l | (~edge_m & {ppi_level_i, {N_SGI{1'b0}}});
  assign mask      = ns_view ? group_o : '1;

  always_comb begin
    unique case (sel)
      SEL_SLEEP:            rd_mux = {30'b0, sleep, sleep};
      SEL_GROUP:            rd_mux = ns_view ? '0 : group_o;
      SEL_SEN, SEL_CEN:     rd_mux = enable_o & mask;
      SEL_SPEND, SEL_CPEND: rd_mux = pending_o & mask;
      SEL_SACT, SEL_CACT:   rd_mux = active_o & mask;
      SEL_PRIO:             rd_mux = prio_rd;
      SEL_CFG0:             rd_mux = spread_odd(edge_m[N_SGI-1:0] & mask[N_SGI-1:0]);
      SEL_CFG1:             rd_mux = spread_odd(edge_m[N_IRQ-1:N_SGI] & mask[N_IRQ-1:N_SGI]);
      SEL_GMOD:             rd_mux = sec_bank ? grpmod_o : '0;
      SEL_NSAC:             rd_mux = sec_bank ? nsacr : '0;
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  assert_unimpl_raz_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel == SEL_NONE) |=> (rdata_o == '0));

  assert_sleep_mirror_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel == SEL_SLEEP) |=> (rdata_o[1] == rdata_o[0]));

  assert_sgi_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sgi_set) && sgi_set[N_IRQ-1:N_SGI] == '0);

  assert_ns_gmod_wi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_GMOD && !sec_bank) |=> $stable(grpmod_o));
endmodule

// File: tb/prv_irq_bank_tb.sv
module prv_irq_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_dis = 0, req = 0, we = 0, sec = 0, word = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] ppi = '0;
  logic sgi_req = 0, sgi_sec = 0;
  logic [3:0] sgi_id = '0;
  logic [1:0] sgi_grp = '0;
  logic [31:0] group, grpmod, enable, pending, active;
  logic [255:0] prio;

  int n_chk = 0, n_fail = 0;
  logic done = 0, rd_pend = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prv_irq_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sec_disable_i(sec_dis), .req_i(req), .we_i(we),
    .secure_i(sec), .word_i(word), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ppi_level_i(ppi), .sgi_req_i(sgi_req), .sgi_id_i(sgi_id), .sgi_grp_i(sgi_grp),
    .sgi_secure_i(sgi_sec), .group_o(group), .grpmod_o(grpmod), .enable_o(enable),
    .pending_o(pending), .active_o(active), .prio_o(prio)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // monitor: a read captured at the last rising edge is compared now
  always @(posedge clk) rd_pend <= req && !we;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual %h expected none", rdata);
      end else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic rd(input logic [11:0] a, input logic w, input logic s,
                    input logic [31:0] e, input string t);
    @(negedge clk);
    req = 1; we = 0; addr = a; word = w; sec = s;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic w, input logic s, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; word = w; sec = s; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic sgi(input logic [3:0] id, input logic [1:0] g, input logic s);
    @(negedge clk);
    sgi_req = 1; sgi_id = id; sgi_grp = g; sgi_sec = s;
    @(negedge clk);
    sgi_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL timeout: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(pending | enable | active | group, 32'h0, "R1 state");
    chk(prio[31:0], 32'h0, "R1 prio");
    rd(12'hC00, 1, 1, 32'hAAAA_AAAA, "R1 sgi edge");
    rd(12'hC04, 1, 1, 32'h0, "R1 ppi level");
    rd(12'h000, 1, 1, 32'h0, "R1 sleep");
    // R10 group register
    wr(12'h080, 1, 1, 32'h0000_F0F0);
    rd(12'h080, 1, 1, 32'h0000_F0F0, "R10 secure read");
    rd(12'h080, 1, 0, 32'h0, "R10 ns read");
    wr(12'h080, 1, 0, 32'hFFFF_FFFF);
    chk(group, 32'h0000_F0F0, "R10 ns write ignored");
    // R2/R3 enable
    wr(12'h100, 1, 0, 32'hFFFF_FFFF);
    chk(enable, 32'h0000_F0F0, "R3 ns set masked");
    wr(12'h100, 1, 1, 32'h0000_0003);
    chk(enable, 32'h0000_F0F3, "R2 secure set");
    rd(12'h180, 1, 0, 32'h0000_F0F0, "R3 ns read masked");
    wr(12'h180, 1, 0, 32'h0000_FFFF);
    rd(12'h100, 1, 1, 32'h0000_0003, "R3 ns clear masked");
    wr(12'h180, 1, 1, 32'h0000_0001);
    chk(enable, 32'h0000_0002, "R2 secure clear");
    // R2/R3 active
    wr(12'h300, 1, 1, 32'h8000_0001);
    wr(12'h380, 1, 0, 32'hFFFF_FFFF);
    rd(12'h380, 1, 1, 32'h8000_0001, "R3 ns active clear ignored");
    rd(12'h300, 1, 0, 32'h0, "R3 ns active read");
    // R4/R5 priorities
    wr(12'h400, 1, 1, 32'h4433_2211);
    chk(prio[31:0], 32'h4433_2211, "R4 word lane order");
    rd(12'h400, 0, 1, 32'h11, "R4 byte 0");
    rd(12'h403, 0, 1, 32'h44, "R4 byte 3");
    wr(12'h405, 0, 1, 32'hA0);
    rd(12'h404, 1, 1, 32'h0000_A000, "R4 byte write");
    rd(12'h404, 1, 0, 32'h0000_4000, "R5 ns read shift");
    wr(12'h406, 0, 0, 32'h40);
    rd(12'h406, 0, 1, 32'hA0, "R5 ns write remap");
    wr(12'h400, 1, 0, 32'hFFFF_FFFF);
    rd(12'h400, 1, 1, 32'h4433_2211, "R5 group0 ignored");
    // security off
    sec_dis = 1;
    rd(12'h080, 1, 0, 32'h0000_F0F0, "R10 sec off ns read");
    wr(12'h401, 0, 0, 32'h55);
    rd(12'h400, 1, 1, 32'h4433_5511, "R5 sec off no remap");
    sec_dis = 0;
    // R7 trigger config
    wr(12'hC04, 1, 1, 32'h0000_000F);
    rd(12'hC04, 1, 1, 32'h0000_000A, "R7 odd bits kept");
    wr(12'hC00, 1, 1, 32'h0);
    rd(12'hC00, 1, 1, 32'hAAAA_AAAA, "R7 sgi cfg ignored");
    wr(12'hC04, 1, 0, 32'hFFFF_FFFF);
    rd(12'hC04, 1, 1, 32'h0000_000A, "R7 ns write masked");
    rd(12'hC04, 1, 0, 32'h0, "R7 ns read masked");
    // R6/R8 peripheral lines: irq16 edge, irq18 level
    @(negedge clk); ppi = 16'h0004;
    @(negedge clk);
    chk(pending, 32'h0004_0000, "R6 level visible");
    rd(12'h200, 1, 1, 32'h0004_0000, "R6 pending read");
    ppi = 16'h0000;
    @(negedge clk);
    chk(pending, 32'h0, "R8 level not latched");
    ppi = 16'h0001;
    @(negedge clk);
    ppi = 16'h0000;
    @(negedge clk);
    rd(12'h200, 1, 1, 32'h0001_0000, "R8 edge latched");
    wr(12'h280, 1, 1, 32'h0001_0000);
    chk(pending, 32'h0, "R2 pending clear");
    // R13 sleep
    wr(12'h000, 1, 1, 32'hFFFF_FFFF);
    rd(12'h000, 1, 1, 32'h3, "R13 sleep set");
    wr(12'h000, 1, 0, 32'h0);
    rd(12'h000, 1, 1, 32'h0, "R13 sleep clear");
    // R9 modifier and permission
    wr(12'hD00, 1, 1, 32'h0000_0002);
    rd(12'hD00, 1, 0, 32'h0, "R9 ns read");
    wr(12'hD00, 1, 0, 32'hFFFF);
    rd(12'hD00, 1, 1, 32'h2, "R9 ns write ignored");
    sec_dis = 1;
    rd(12'hD00, 1, 1, 32'h0, "R9 sec off read");
    wr(12'hD00, 1, 1, 32'hFF);
    sec_dis = 0;
    chk(grpmod, 32'h2, "R9 sec off write ignored");
    wr(12'hE00, 1, 1, 32'h4);
    rd(12'hE00, 1, 1, 32'h4, "R9 permission");
    // R11 group match: irq0/2 group0, irq1 secure group1, irq4 ns group1
    sgi(0, 2'd1, 1);
    chk(pending, 32'h1, "R11 g1s on g0 accepted");
    sgi(2, 2'd2, 1);
    chk(pending, 32'h1, "R11 mismatch dropped");
    sgi(1, 2'd0, 1);
    chk(pending, 32'h1, "R11 g0 on g1s dropped");
    sgi(1, 2'd1, 1);
    chk(pending, 32'h3, "R11 g1s match");
    // R12 permission fields
    sgi(2, 2'd0, 0);
    chk(pending, 32'h3, "R12 ns g0 no permission");
    wr(12'h280, 1, 1, 32'h2);
    sgi(1, 2'd1, 0);
    chk(pending, 32'h1, "R12 ns g1s field 1 dropped");
    wr(12'hE00, 1, 1, 32'h8);
    sgi(1, 2'd1, 0);
    chk(pending, 32'h3, "R12 ns g1s field 2 accepted");
    sgi(4, 2'd2, 0);
    chk(pending, 32'h13, "R12 ns g1ns accepted");
    // R14 unmapped
    rd(12'h7F0, 1, 1, 32'h0, "R14 unmapped");
    rd(12'h080, 0, 1, 32'h0, "R14 byte outside prio");
    wr(12'h080, 0, 1, 32'hFF);
    rd(12'h080, 1, 1, 32'h0000_F0F0, "R14 byte write ignored");
    rd(12'h102, 1, 1, 32'h0, "R14 misaligned");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'h0, "scoreboard drained");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule